// File: doc/BRIEF.md
# DRAM Address Multiplexer and Refresh Controller

This block sits between a processor address bus and a DRAM array of four banks. It holds an 18-bit address and a 2-bit bank selection in a latch that follows its inputs while the strobe `ads` is high. During an access it places the 9-bit row half on a multiplexed address bus, waits a selectable hold time, and then places the 9-bit column half there. It drives four active-low row strobes, one column strobe and one write strobe. The column strobe is either timed by the block or passed through from the host. A 9-bit internal counter supplies row addresses for row-strobe-only refresh, and every refresh cycle lowers all four row strobes together.

The controller is a four-state machine. `ST_IDLE` waits and shows the latched row. A low `ras_in_n` takes it to `ST_ROW`, and it returns to `ST_IDLE` if `ras_in_n` rises. `ST_ROW` moves to `ST_COL` once the hold count is reached. `ST_COL` returns to `ST_IDLE` when `ras_in_n` rises. In `ST_IDLE`, when `ras_in_n` is high and a refresh request is present or pending, the machine enters `ST_REFRESH`. `ST_REFRESH` returns to `ST_IDLE` after `REF_CYCLES` clocks. All delays are counted in clock cycles.

Top module: `dram_mux_ctrl`

## Requirements
- R1: At each rising clock edge while `ads` is high, the latch captures `addr_in` and `bank_in`. While `ads` is low, the latch keeps its contents. The row is `addr_in[8:0]` and the column is `addr_in[17:9]`.
- R2: With `pair_mode` low, a latched bank value of 0, 1, 2 or 3 enables only `ras_n[0]`, `ras_n[1]`, `ras_n[2]` or `ras_n[3]` respectively.
- R3: With `pair_mode` high, only bank bit 1 is decoded. A 0 enables `ras_n[1:0]` together, and a 1 enables `ras_n[3:2]` together.
- R4: Outside refresh, each enabled row strobe equals `ras_in_n` in the same cycle, and every strobe that is not enabled stays high.
- R5: An access starts at the clock edge that sees `ras_in_n` low. The row stays on `mux_addr` for that edge and for the following hold time, which is 1 clock with `long_hold` low and 2 clocks with `long_hold` high. After that, the column appears.
- R6: A refresh holds all four `ras_n` low and drives the counter value on `mux_addr` for `REF_CYCLES` (default 3) clocks. `cas_n` stays high throughout.
- R7: With `auto_cas` high, `cas_n` goes low one clock after the column appears, and it stays low while `ras_in_n` is low.
- R8: With `auto_cas` low, `cas_n` equals `cas_in_n` while the column is shown and `ras_in_n` is low. At all other times outside this window, `cas_n` is high.
- R9: `we_n` equals `wr_in_n` in every cycle and in every mode.
- R10: The refresh counter adds one at the end of each refresh and wraps at 9 bits. A low `cnt_clr_n` sampled at a clock edge sets it to zero.
- R11: A one-clock `refresh_req` pulse that arrives during an access is held. The refresh starts at the second clock edge after `ras_in_n` rises.
- R12: Reset leaves all row strobes high, the column strobe high and the counter at zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| ads | input | 1 | Latch follows its inputs while high |
| addr_in | input | 18 | Column in bits 17:9, row in bits 8:0 |
| bank_in | input | 2 | Bank selection |
| pair_mode | input | 1 | 1 = banks are enabled in pairs |
| auto_cas | input | 1 | 1 = column strobe timed internally |
| long_hold | input | 1 | 1 = two-clock row hold |
| ras_in_n | input | 1 | Host row strobe, active low |
| cas_in_n | input | 1 | Host column strobe, active low |
| wr_in_n | input | 1 | Host write strobe, active low |
| refresh_req | input | 1 | Refresh request |
| cnt_clr_n | input | 1 | Clears the refresh counter when low |
| mux_addr | output | 9 | Multiplexed DRAM address |
| ras_n | output | 4 | Row strobes, active low |
| cas_n | output | 1 | Column strobe, active low |
| we_n | output | 1 | Write strobe, active low |

## Verification
Errors in internal state show up at the ports within one or two clocks. A wrong state register makes `mux_addr` switch halves at the wrong edge, or makes `cas_n` fall too early or too late. A lost refresh request leaves all four row strobes high in a cycle where they should be low. A bad refresh counter only becomes visible on `mux_addr` during the next refresh, so the bench runs refreshes back to back and after clears. Each access is checked in every cycle, both for its strobes and for the address half on the bus.

// File: rtl/dmc_pkg.sv
package dmc_pkg;
    typedef enum logic [1:0] {
        ST_IDLE    = 2'd0,
        ST_ROW     = 2'd1,
        ST_COL     = 2'd2,
        ST_REFRESH = 2'd3
    } dmc_state_e;

    localparam int NUM_RAS = 4;
endpackage

// File: rtl/dmc_addr_latch.sv
module dmc_addr_latch #(
    parameter int AW = 9
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            ads,
    input  logic [2*AW-1:0] addr_in,
    input  logic [1:0]      bank_in,
    output logic [AW-1:0]   row_q,
    output logic [AW-1:0]   col_q,
    output logic [1:0]      bank_q
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            row_q  <= '0;
            col_q  <= '0;
            bank_q <= '0;
        end else if (ads) begin
            row_q  <= addr_in[AW-1:0];
            col_q  <= addr_in[2*AW-1:AW];
            bank_q <= bank_in;
        end
    end
endmodule

// File: rtl/dmc_bank_decode.sv
module dmc_bank_decode
    import dmc_pkg::*;
(
    input  logic               pair_mode,
    input  logic [1:0]         bank,
    output logic [NUM_RAS-1:0] bank_en
);
    for (genvar g = 0; g < NUM_RAS; g++) begin : g_line
        always_comb begin
            if (pair_mode)
                bank_en[g] = (bank[1] == g[1]);
            else
                bank_en[g] = (bank == g[1:0]);
        end
    end
endmodule

// File: rtl/dmc_refresh_counter.sv
module dmc_refresh_counter #(
    parameter int AW = 9
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          clr_n,
    input  logic          inc,
    output logic [AW-1:0] cnt
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            cnt <= '0;
        else if (!clr_n)
            cnt <= '0;
        else if (inc)
            cnt <= cnt + 1'b1;
    end
endmodule

// File: rtl/dram_mux_ctrl.sv
module dram_mux_ctrl
    import dmc_pkg::*;
#(
    parameter int AW         = 9,
    parameter int REF_CYCLES = 3,
    parameter int HOLD_SHORT = 1,
    parameter int HOLD_LONG  = 2
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               ads,
    input  logic [2*AW-1:0]    addr_in,
    input  logic [1:0]         bank_in,
    input  logic               pair_mode,
    input  logic               auto_cas,
    input  logic               long_hold,
    input  logic               ras_in_n,
    input  logic               cas_in_n,
    input  logic               wr_in_n,
    input  logic               refresh_req,
    input  logic               cnt_clr_n,
    output logic [AW-1:0]      mux_addr,
    output logic [NUM_RAS-1:0] ras_n,
    output logic               cas_n,
    output logic               we_n
);
    localparam int MAXC = (REF_CYCLES > HOLD_LONG) ? REF_CYCLES : HOLD_LONG;
    localparam int CW   = (MAXC < 2) ? 1 : $clog2(MAXC + 1);
    localparam logic [CW-1:0] REF_LAST   = CW'(REF_CYCLES - 1);
    localparam logic [CW-1:0] SHORT_LAST = CW'(HOLD_SHORT - 1);
    localparam logic [CW-1:0] LONG_LAST  = CW'(HOLD_LONG - 1);

    dmc_state_e          state, nxt;
    logic [CW-1:0]       step_cnt;
    logic                cas_ready;
    logic                pend;
    logic                go_ref;
    logic                ref_done;
    logic [CW-1:0]       hold_last;
    logic [AW-1:0]       row_q, col_q, ref_cnt;
    logic [1:0]          bank_q;
    logic [NUM_RAS-1:0]  bank_en;

    dmc_addr_latch #(.AW(AW)) u_latch (
        .clk(clk), .rst_n(rst_n), .ads(ads), .addr_in(addr_in),
        .bank_in(bank_in), .row_q(row_q), .col_q(col_q), .bank_q(bank_q)
    );

    dmc_bank_decode u_decode (
        .pair_mode(pair_mode), .bank(bank_q), .bank_en(bank_en)
    );

    dmc_refresh_counter #(.AW(AW)) u_refcnt (
        .clk(clk), .rst_n(rst_n), .clr_n(cnt_clr_n),
        .inc(ref_done), .cnt(ref_cnt)
    );

    assign hold_last = long_hold ? LONG_LAST : SHORT_LAST;
    assign we_n      = wr_in_n;

    // next-state selection
    always_comb begin
        nxt      = state;
        go_ref   = 1'b0;
        ref_done = 1'b0;
        unique case (state)
            ST_IDLE: begin
                if (!ras_in_n)
                    nxt = ST_ROW;
                else if (pend || refresh_req) begin
                    nxt    = ST_REFRESH;
                    go_ref = 1'b1;
                end
            end
            ST_ROW: begin
                if (ras_in_n)
                    nxt = ST_IDLE;
                else if (step_cnt == hold_last)
                    nxt = ST_COL;
            end
            ST_COL: begin
                if (ras_in_n)
                    nxt = ST_IDLE;
            end
            ST_REFRESH: begin
                if (step_cnt == REF_LAST) begin
                    nxt      = ST_IDLE;
                    ref_done = 1'b1;
                end
            end
            default: nxt = ST_IDLE;
        endcase
    end

    // state register and cycle counters
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state     <= ST_IDLE;
            step_cnt  <= '0;
            cas_ready <= 1'b0;
            pend      <= 1'b0;
        end else begin
            state     <= nxt;
            cas_ready <= (state == ST_COL) && (nxt == ST_COL);
            if (nxt != state)
                step_cnt <= '0;
            else if (state == ST_ROW || state == ST_REFRESH)
                step_cnt <= step_cnt + 1'b1;
            if (go_ref)
                pend <= 1'b0;
            else if (refresh_req)
                pend <= 1'b1;
        end
    end

    // output decode
    always_comb begin
        ras_n    = '1;
        cas_n    = 1'b1;
        mux_addr = row_q;
        unique case (state)
            ST_IDLE, ST_ROW: begin
                ras_n    = ras_in_n ? '1 : ~bank_en;
                mux_addr = row_q;
            end
            ST_COL: begin
                ras_n    = ras_in_n ? '1 : ~bank_en;
                mux_addr = col_q;
                if (!ras_in_n)
                    cas_n = auto_cas ? ~cas_ready : cas_in_n;
            end
            ST_REFRESH: begin
                ras_n    = '0;
                mux_addr = ref_cnt;
            end
            default: begin
                ras_n = '1;
            end
        endcase
    end
endmodule

// File: rtl/dmc_checker.sv
module dmc_checker #(
    parameter int AW = 9
) (
    input logic          clk,
    input logic          rst_n,
    input logic [3:0]    ras_n,
    input logic          cas_n,
    input logic          ras_in_n,
    input logic          pair_mode,
    input logic          cnt_clr_n,
    input logic [AW-1:0] ref_cnt
);
    assert_cas_idle_in_refresh_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (ras_n == 4'b0000) |-> cas_n);

    assert_ras_width_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (ras_n != 4'b0000) |-> ($countones(~ras_n) <= (pair_mode ? 2 : 1)));

    assert_ras_released_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (ras_in_n && ras_n != 4'b0000) |-> (ras_n == 4'b1111));

    assert_cas_needs_ras_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !cas_n |-> (ras_n != 4'b1111));

    assert_counter_clear_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !cnt_clr_n |=> (ref_cnt == '0));
endmodule

bind dram_mux_ctrl dmc_checker #(.AW(AW)) u_chk (
    .clk(clk), .rst_n(rst_n), .ras_n(ras_n), .cas_n(cas_n),
    .ras_in_n(ras_in_n), .pair_mode(pair_mode),
    .cnt_clr_n(cnt_clr_n), .ref_cnt(ref_cnt)
);

// File: tb/dram_mux_ctrl_bench.sv
module dram_mux_ctrl_bench;
    localparam int REF = 3;

    logic clk = 0, rst_n = 0;
    logic ads = 0, pair_mode = 0, auto_cas = 1, long_hold = 0;
    logic ras_in_n = 1, cas_in_n = 1, wr_in_n = 1, refresh_req = 0, cnt_clr_n = 1;
    logic [17:0] addr_in = '0;
    logic [1:0]  bank_in = '0;
    logic [8:0]  mux_addr;
    logic [3:0]  ras_n;
    logic        cas_n, we_n;

    int total = 0, bad = 0;
    logic [8:0] mcnt = '0;

    always #5 clk = ~clk;

    dram_mux_ctrl u_dram_mux_ctrl (
        .clk(clk), .rst_n(rst_n), .ads(ads), .addr_in(addr_in), .bank_in(bank_in),
        .pair_mode(pair_mode), .auto_cas(auto_cas), .long_hold(long_hold),
        .ras_in_n(ras_in_n), .cas_in_n(cas_in_n), .wr_in_n(wr_in_n),
        .refresh_req(refresh_req), .cnt_clr_n(cnt_clr_n),
        .mux_addr(mux_addr), .ras_n(ras_n), .cas_n(cas_n), .we_n(we_n)
    );

    function automatic logic [3:0] exp_ras(input logic [1:0] b, input logic pr, input logic rin);
        logic [3:0] en;
        if (pr) en = b[1] ? 4'b1100 : 4'b0011;
        else    en = 4'b0001 << b;
        return rin ? 4'b1111 : ~en;
    endfunction

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic tick();
        @(posedge clk);
        #1;
        wr_in_n = 1'($urandom % 2);
    endtask

    task automatic look(input string tag, input bit do_addr, input logic [8:0] ea,
                        input logic [3:0] er, input logic ec);
        #1;
        if (do_addr) chk({tag, " addr"}, 32'(mux_addr), 32'(ea));
        chk({tag, " ras"}, 32'(ras_n), 32'(er));
        chk({tag, " cas"}, 32'(cas_n), 32'(ec));
        chk("R9 we", 32'(we_n), 32'(wr_in_n));
    endtask

    task automatic run_refresh(input bit pending);
        tick();
        if (!pending) refresh_req = 1;
        look("R11 idle", 0, '0, 4'hF, 1);
        for (int i = 0; i < REF; i++) begin
            tick();
            refresh_req = 0;
            look("R6 refresh", 1, mcnt, 4'h0, 1);
        end
        tick();
        look("R10 after refresh", 0, '0, 4'hF, 1);
        mcnt = mcnt + 1'b1;
    endtask

    task automatic clear_cnt();
        tick();
        cnt_clr_n = 0;
        look("R10 clr", 0, '0, 4'hF, 1);
        tick();
        cnt_clr_n = 1;
        look("R10 clr", 0, '0, 4'hF, 1);
        mcnt = '0;
    endtask

    task automatic access(input logic [8:0] row, input logic [8:0] col, input logic [1:0] b,
                          input logic pr, input logic au, input logic lh, input bit req_mid);
        int h;
        logic ec;
        h = lh ? 2 : 1;
        tick();
        ads = 1; addr_in = {col, row}; bank_in = b;
        pair_mode = pr; auto_cas = au; long_hold = lh;
        look("R4 idle", 0, '0, 4'hF, 1);
        tick();
        ads = 0; addr_in = 18'($urandom); bank_in = 2'($urandom);
        ras_in_n = 0;
        look(pr ? "R1/R3 start" : "R1/R2 start", 1, row, exp_ras(b, pr, 0), 1);
        for (int k = 1; k <= h + 3; k++) begin
            tick();
            refresh_req = (req_mid && k == 1);
            if (!au) cas_in_n = 1'($urandom % 2);
            if (k <= h) ec = 1;
            else if (au) ec = (k == h + 1);
            else ec = cas_in_n;
            look(k <= h ? "R5 row" : (au ? "R7 col" : "R8 col"), 1,
                 k <= h ? row : col, exp_ras(b, pr, 0), ec);
        end
        tick();
        ras_in_n = 1; cas_in_n = 1; refresh_req = 0;
        look("R4 release", 1, col, 4'hF, 1);
    endtask

    initial begin
        #2_000_000;
        bad++; total++;
        $display("FAIL watchdog actual=running expected=done");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        void'($urandom(32'd2718));
        repeat (3) @(posedge clk);
        #1;
        look("R12 reset", 0, '0, 4'hF, 1);
        rst_n = 1;
        // R12: counter starts at zero
        run_refresh(0);
        run_refresh(0);
        for (int b = 0; b < 4; b++) access(9'h0A5 + 9'(b), 9'h15A, 2'(b), 0, 1, 0, 0);
        access(9'h1FF, 9'h000, 2'd1, 1, 1, 1, 0);
        access(9'h000, 9'h1FF, 2'd2, 1, 0, 0, 0);
        access(9'h123, 9'h0CD, 2'd3, 0, 0, 1, 0);
        access(9'h055, 9'h0AA, 2'd0, 0, 1, 1, 1);
        run_refresh(1);
        clear_cnt();
        run_refresh(0);
        for (int it = 0; it < 150; it++) begin
            int r;
            r = int'($urandom % 8);
            if (r == 0) run_refresh(0);
            else if (r == 1) begin clear_cnt(); run_refresh(0); end
            else begin
                bit rm;
                rm = ($urandom % 6) == 0;
                access(9'($urandom), 9'($urandom), 2'($urandom), 1'($urandom),
                       1'($urandom), 1'($urandom), rm);
                if (rm) run_refresh(1);
            end
        end
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule